// File: doc/BRIEF.md
# LIN Transceiver Operating-Mode Controller

This block decides which operating mode a LIN physical-layer interface is in, using only digital inputs. These inputs are a supply power-good flag, an active-low sleep-control input and the digitised bus receiver level. All of them are asynchronous. They are resynchronised on the system clock and timed against a one-cycle microsecond tick supplied from outside.

The controller has four modes: Reset, Sleep, Standby and Normal. Two timing filters act on the sleep-control line, one for leaving Sleep or Standby and one for entering Sleep from Normal. A third filter looks for a remote wake-up pulse on the bus: a falling edge, then a long enough dominant period, then a rising edge.

The controller drives the receive-data pin through an enable/value pair, which gives three pin states: released, driven low, or following the bus. It also produces a transmit-permit signal for a separate transmit guard block. The current mode is available as a two-bit status output.

Top module: `lin_mode_ctrl`

## Requirements
- R1: When power-good becomes true, the mode leaves Reset for Sleep (`mode_o`=1) and never goes straight to Normal. The mode codes are 0 Reset, 1 Sleep, 2 Standby and 3 Normal.
- R2: While power-good is false, the mode is Reset (0), whatever the previous mode. The same holds while `rst_n` is low. In Reset, `rxd_en`=0, `rxd_val`=1 and `tx_permit`=0, and changes on the sleep-control and bus inputs have no effect.
- R3: In Sleep, `rxd_en`=0, `rxd_val`=1 and `tx_permit`=0.
- R4: Sleep moves to Standby only after this exact sequence on the bus: a falling edge seen while in Sleep, a low level held for at least `WAKE_US` ticks, then a rising edge. A shorter low period does not wake the block. A low level already present on entry to Sleep, with no falling edge seen in Sleep, does not wake it either.
- R5: In Standby, `rxd_en`=1 and `rxd_val`=0, which acts as the wake interrupt, and `tx_permit`=0. Bus activity does not change this.
- R6: Sleep or Standby moves to Normal once `slp_n` has been high continuously for `GO_NORM_US` ticks. A shorter high period, or an interrupted one, restarts the count from zero and does not change the mode. Leaving Standby this way releases the wake interrupt.
- R7: In Normal, `rxd_en`=1 and `rxd_val` follows the bus: 1 when the bus is recessive, 0 when it is dominant.
- R8: In Normal, `tx_permit` is 1 while `slp_n` is high. It drops as soon as the synchronised `slp_n` goes low, before the go-to-sleep time has elapsed.
- R9: Normal moves to Sleep once `slp_n` has been low continuously for `GO_SLEEP_US` ticks, even when the bus is dominant. A shorter low period leaves the mode in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| pwr_good | input | 1 | Supply power-good flag (asynchronous) |
| slp_n | input | 1 | Active-low sleep-control input (asynchronous) |
| bus_rx | input | 1 | Digitised bus level, 1 = recessive (asynchronous) |
| rxd_en | output | 1 | 1 = receive pin driven, 0 = released |
| rxd_val | output | 1 | Receive pin level when driven (1 when released) |
| tx_permit | output | 1 | Transmitter may be enabled |
| mode_o | output | 2 | Current mode code |

## Verification
The hardest cases to reach are the remote wake-up corners. One is a dominant bus that is already low when Sleep is entered. The other is a dominant pulse that is too short before its rising edge. The stimulus reaches the first by entering Sleep from Normal with the bus held dominant, so no falling edge ever happens inside Sleep, and then releasing the bus after well over the wake time. A short pulse and a long pulse are each applied back to back with a release, and a sleep-control high period is split by a brief low to show that the filter count restarts.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
   typedef enum logic [1:0] {
      LM_RESET   = 2'd0,
      LM_SLEEP   = 2'd1,
      LM_STANDBY = 2'd2,
      LM_NORMAL  = 2'd3
   } lin_mode_e;
endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lin_hold_filter.sv
module lin_hold_filter #(
   parameter int COUNT = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lvl,
   input  logic tick,
   output logic done
);
   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] LIMIT = CW'(COUNT);

   if (COUNT < 1) begin : g_bad_count
      $error("lin_hold_filter: COUNT must be positive");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (clr || !lvl)              cnt <= '0;
      else if (tick && cnt != LIMIT)     cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIMIT);
endmodule

// File: rtl/lin_wake_det.sv
module lin_wake_det #(
   parameter int WAKE_US = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bus,
   input  logic tick,
   output logic wake
);
   logic bus_q;
   logic armed;
   logic long_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_q <= 1'b1;
         armed <= 1'b0;
      end else begin
         bus_q <= bus;
         if (!en)                armed <= 1'b0;
         else if (bus_q && !bus) armed <= 1'b1;
         else if (!bus_q && bus) armed <= 1'b0;
      end
   end

   lin_hold_filter #(.COUNT(WAKE_US)) u_low (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!en),
      .lvl  (armed && !bus),
      .tick (tick),
      .done (long_low)
   );

   assign wake = en && armed && !bus_q && bus && long_low;
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GO_NORM_US  = 6,
   parameter int GO_SLEEP_US = 6,
   parameter int WAKE_US     = 80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       us_tick,
   input  logic       pwr_good,
   input  logic       slp_n,
   input  logic       bus_rx,
   output logic       rxd_en,
   output logic       rxd_val,
   output logic       tx_permit,
   output logic [1:0] mode_o
);
   if (WAKE_US <= GO_NORM_US) begin : g_bad_wake
      $error("lin_mode_ctrl: WAKE_US must exceed GO_NORM_US");
   end

   logic [2:0] raw_in, syn_in;
   logic pg_s, slp_s, bus_s;
   logic norm_done, sleep_done, wake_hit;
   lin_mode_e mode_q, mode_d;

   assign raw_in = {pwr_good, slp_n, bus_rx};

   lin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );
   assign {pg_s, slp_s, bus_s} = syn_in;

   lin_hold_filter #(.COUNT(GO_NORM_US)) u_norm_flt (
      .clk(clk), .rst_n(rst_n),
      .clr(mode_q == LM_RESET || mode_q == LM_NORMAL),
      .lvl(slp_s), .tick(us_tick), .done(norm_done)
   );

   lin_hold_filter #(.COUNT(GO_SLEEP_US)) u_sleep_flt (
      .clk(clk), .rst_n(rst_n),
      .clr(mode_q != LM_NORMAL),
      .lvl(!slp_s), .tick(us_tick), .done(sleep_done)
   );

   lin_wake_det #(.WAKE_US(WAKE_US)) u_wake (
      .clk(clk), .rst_n(rst_n), .en(mode_q == LM_SLEEP),
      .bus(bus_s), .tick(us_tick), .wake(wake_hit)
   );

   always_comb begin
      mode_d = mode_q;
      if (!pg_s) mode_d = LM_RESET;
      else begin
         unique case (mode_q)
            LM_RESET:   mode_d = LM_SLEEP;
            LM_SLEEP:   if (norm_done)     mode_d = LM_NORMAL;
                        else if (wake_hit) mode_d = LM_STANDBY;
            LM_STANDBY: if (norm_done)     mode_d = LM_NORMAL;
            LM_NORMAL:  if (sleep_done)    mode_d = LM_SLEEP;
            default:    mode_d = LM_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= LM_RESET;
      else        mode_q <= mode_d;
   end

   always_comb begin
      rxd_en    = 1'b0;
      rxd_val   = 1'b1;
      tx_permit = 1'b0;
      case (mode_q)
         LM_STANDBY: begin rxd_en = 1'b1; rxd_val = 1'b0; end
         LM_NORMAL:  begin rxd_en = 1'b1; rxd_val = bus_s; tx_permit = slp_s; end
         default:    ;
      endcase
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk
   import lin_mode_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       rxd_en,
   input logic       rxd_val,
   input logic       tx_permit,
   input logic [1:0] mode_o
);
   assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == LM_RESET && mode_o != LM_RESET) |-> mode_o == LM_SLEEP);

   assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == LM_RESET) |-> (!rxd_en && rxd_val && !tx_permit));

   assert_sleep_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == LM_SLEEP) |-> (!rxd_en && rxd_val && !tx_permit));

   assert_standby_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == LM_STANDBY && $past(mode_o) != LM_STANDBY) |-> $past(mode_o) == LM_SLEEP);

   assert_standby_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == LM_STANDBY) |-> (rxd_en && !rxd_val && !tx_permit));

   assert_normal_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == LM_NORMAL) |-> rxd_en);

   assert_permit_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_permit |-> mode_o == LM_NORMAL);

   assert_normal_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == LM_NORMAL && mode_o != LM_NORMAL) |-> (mode_o == LM_SLEEP || mode_o == LM_RESET));
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rxd_en   (rxd_en),
   .rxd_val  (rxd_val),
   .tx_permit(tx_permit),
   .mode_o   (mode_o)
);

// File: tb/lin_mode_ctrl_test.sv
module lin_mode_ctrl_test;
   localparam int TICK_DIV = 4;
   localparam int NVEC = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b0;
   logic pwr_good = 1'b0;
   logic slp_n = 1'b0;
   logic bus_rx = 1'b1;
   logic rxd_en, rxd_val, tx_permit;
   logic [1:0] mode_o;
   int total = 0;
   int bad = 0;
   int tick_cnt = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
      us_tick  <= (tick_cnt == TICK_DIV - 1);
   end

   lin_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pwr_good(pwr_good),
      .slp_n(slp_n), .bus_rx(bus_rx), .rxd_en(rxd_en), .rxd_val(rxd_val),
      .tx_permit(tx_permit), .mode_o(mode_o)
   );

   // {req[3:0], pg, slp, bus, hold_ticks[7:0], mode[1:0], rxd_en, rxd_val, tx_permit}
   localparam logic [19:0] VEC [NVEC] = '{
      {4'd2, 3'b001, 8'd2,   2'd0, 3'b010},  // R2 power low, reset state
      {4'd1, 3'b101, 8'd2,   2'd1, 3'b010},  // R1 power up lands in Sleep
      {4'd6, 3'b111, 8'd4,   2'd1, 3'b010},  // R6 short high, no change
      {4'd6, 3'b101, 8'd1,   2'd1, 3'b010},  // R6 brief low restarts count
      {4'd6, 3'b111, 8'd4,   2'd1, 3'b010},  // R6 second short high
      {4'd3, 3'b101, 8'd2,   2'd1, 3'b010},  // R3 sleep outputs
      {4'd4, 3'b100, 8'd20,  2'd1, 3'b010},  // R4 short dominant pulse
      {4'd4, 3'b101, 8'd2,   2'd1, 3'b010},  // R4 no wake after short pulse
      {4'd4, 3'b100, 8'd100, 2'd1, 3'b010},  // R4 long dominant, no edge yet
      {4'd4, 3'b101, 8'd2,   2'd2, 3'b100},  // R4 rising edge wakes to Standby
      {4'd5, 3'b100, 8'd20,  2'd2, 3'b100},  // R5 bus ignored in Standby
      {4'd6, 3'b111, 8'd3,   2'd2, 3'b100},  // R6 not yet Normal
      {4'd6, 3'b111, 8'd10,  2'd3, 3'b111},  // R6 Standby to Normal
      {4'd7, 3'b110, 8'd2,   2'd3, 3'b101},  // R7 dominant bus seen
      {4'd7, 3'b111, 8'd2,   2'd3, 3'b111},  // R7 recessive bus seen
      {4'd8, 3'b101, 8'd2,   2'd3, 3'b110},  // R8 permit drops at once
      {4'd9, 3'b111, 8'd2,   2'd3, 3'b111},  // R9 short low keeps Normal
      {4'd9, 3'b100, 8'd10,  2'd1, 3'b010},  // R9 sleep with bus dominant
      {4'd4, 3'b100, 8'd100, 2'd1, 3'b010},  // R4 low from entry, no fall
      {4'd4, 3'b101, 8'd2,   2'd1, 3'b010},  // R4 rise without fall: no wake
      {4'd6, 3'b111, 8'd10,  2'd3, 3'b111},  // R6 Sleep to Normal
      {4'd2, 3'b011, 8'd2,   2'd0, 3'b010},  // R2 power loss from Normal
      {4'd2, 3'b010, 8'd20,  2'd0, 3'b010},  // R2 inputs ignored in Reset
      {4'd1, 3'b111, 8'd3,   2'd1, 3'b010},  // R1 power back: Sleep not Normal
      {4'd6, 3'b111, 8'd10,  2'd3, 3'b111}   // R6 Normal after full filter
   };

   task automatic check(input int req, input logic [4:0] got, input logic [4:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL R%0d: {mode,en,val,permit} got %b expected %b", req, got, exp);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(2, {mode_o, rxd_en, rxd_val, tx_permit}, 5'b00010);  // R2 reset state
      rst_n = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         {pwr_good, slp_n, bus_rx} = VEC[i][15:13];
         repeat (int'(VEC[i][12:5]) * TICK_DIV) @(posedge clk);
         @(negedge clk);
         check(int'(VEC[i][19:16]), {mode_o, rxd_en, rxd_val, tx_permit}, VEC[i][4:0]);
      end
      // R2: asynchronous reset forces Reset out of Normal
      rst_n = 1'b0;
      #1;
      check(2, {mode_o, rxd_en, rxd_val, tx_permit}, 5'b00010);
      // R1: after release with power good, the first mode is Sleep
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(1, {mode_o, rxd_en, rxd_val, tx_permit}, 5'b01010);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule